// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns parallel words written by a host into asynchronous serial frames on one output line. Each write carries an 8-bit value and an extra ninth bit. Accepted words wait in a small first-in first-out queue. A frame shifter takes the oldest word whenever it has nothing left to send. Frame format is chosen by static inputs: 8 data bits with no parity, even parity or odd parity, or 9 data bits with no parity, followed by one or two stop bits.

Bit timing comes from an external enable that pulses at sixteen times the baud rate. The block counts those pulses, so a serial bit lasts exactly sixteen of them, however far apart they are in clock cycles. The host sees three flags: a full flag, so that it does not write into a full queue, a one-cycle interrupt pulse each time a word moves from the queue into the shifter, and an idle flag. A break input pulls the line low for as long as it is held.

Top module: `async_tx_engine`

## Requirements
- R1: While reset is held and right after it, `txd_o` is 1, `idle_o` is 1, `full_o` is 0 and `irq_o` is 0.
- R2: A frame is a start bit of 0, then the data bits least significant first, then the stop bits of 1. Every bit lasts exactly 16 pulses of `tick16_i`, counted from the frame's start, for any pulse spacing.
- R3: With `nine_bit_i`=0, `parity_sel_i` 2'b01 adds an even parity bit (the XOR of the 8 data bits) and 2'b10 adds an odd parity bit (its inverse), sent directly after data bit 7. The codes 2'b00 and 2'b11 send no parity bit.
- R4: With `nine_bit_i`=1, the frame carries 9 data bits, with the `wr_bit8_i` value captured at the write sent directly after data bit 7. No parity bit is sent, whatever `parity_sel_i` holds.
- R5: `two_stop_i`=1 sends two stop bits and `two_stop_i`=0 sends one.
- R6: The queue holds 4 words. Words are sent in write order, and the shifter loads the next word on its own as soon as the previous frame has finished.
- R7: `full_o` is 1 while the queue holds 4 words. A write in a cycle in which `full_o` is 1 is dropped and never sent.
- R8: `irq_o` is a one-clock pulse in the first clock cycle of each frame's start bit, once per word moved into the shifter.
- R9: `idle_o` is 1 exactly when the queue is empty and no frame is in progress.
- R10: While `brk_i` is 1, `txd_o` is 0. The break does not stop or stretch a frame in progress, which ends at the same cycle it would have ended without the break.
- R11: While no frame is in progress and `brk_i` is 0, `txd_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick16_i | input | 1 | Enable at 16 times the baud rate |
| wr_en_i | input | 1 | Write strobe, one word per cycle |
| wr_data_i | input | 8 | Low 8 bits of the written word |
| wr_bit8_i | input | 1 | Ninth bit of the written word |
| nine_bit_i | input | 1 | 1 selects 9-bit frames |
| parity_sel_i | input | 2 | 01 even, 10 odd, 00 or 11 none (8-bit frames only) |
| two_stop_i | input | 1 | 1 selects two stop bits |
| brk_i | input | 1 | Force the line low |
| txd_o | output | 1 | Serial output line |
| full_o | output | 1 | Queue holds 4 words |
| idle_o | output | 1 | Queue empty and shifter idle |
| irq_o | output | 1 | One-cycle pulse per word moved into the shifter |

## Verification
A host write and the shifter pulling a word out of the queue can land in the same clock cycle, and so can a write against a full queue and a pop. A burst of six back-to-back writes into an empty queue provokes both: the second write coincides with the first pop, and the sixth write meets a full queue. The bench judges the result by checking that exactly the first five words come out as frames, in order, with one interrupt each. Break and an active frame also overlap: break is raised in the middle of a frame, and the frame must still end on the same cycle as an identical frame sent without a break.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

  localparam int BASE_W = 8;

  typedef enum logic [1:0] {
    PAR_OFF  = 2'b00,
    PAR_EVEN = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_OFF2 = 2'b11
  } par_mode_e;

  typedef struct packed {
    logic              bit8;
    logic [BASE_W-1:0] data;
  } tx_word_t;

endpackage

// File: rtl/tx_word_fifo.sv
module tx_word_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign dout_o  = mem_q[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) begin
      wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    end
    if (do_pop) begin
      rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    end
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      mem_q[wr_q] <= din_i;
    end
  end

endmodule

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic run_i,
  input  logic tick_i,
  output logic bit_end_o
);

  localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign bit_end_o = run_i && tick_i && (cnt_q == CW'(OVS - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i) begin
      cnt_d = '0;
    end else if (run_i && tick_i) begin
      cnt_d = bit_end_o ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/tx_frame_shifter.sv
module tx_frame_shifter
  import async_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load_i,
  input  tx_word_t  word_i,
  input  logic      nine_bit_i,
  input  par_mode_e par_i,
  input  logic      two_stop_i,
  input  logic      bit_end_i,
  output logic      busy_o,
  output logic      line_o
);

  localparam int FRAME_W = 1 + BASE_W + 1 + 2;
  localparam int LW      = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sh_q, sh_d, frame;
  logic [LW-1:0]      left_q, left_d, nbits;
  logic               busy_q, busy_d;
  logic               has_ext, ext_bit;

  always_comb begin
    has_ext = nine_bit_i || (par_i == PAR_EVEN) || (par_i == PAR_ODD);
    if (nine_bit_i) begin
      ext_bit = word_i.bit8;
    end else if (par_i == PAR_ODD) begin
      ext_bit = ~^word_i.data;
    end else begin
      ext_bit = ^word_i.data;
    end
    frame              = '1;
    frame[0]           = 1'b0;
    frame[BASE_W:1]    = word_i.data;
    if (has_ext) begin
      frame[BASE_W+1] = ext_bit;
    end
    nbits = LW'(1 + BASE_W) + LW'(has_ext) + (two_stop_i ? LW'(2) : LW'(1));
  end

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    busy_d = busy_q;
    if (load_i) begin
      sh_d   = frame;
      left_d = nbits;
      busy_d = 1'b1;
    end else if (busy_q && bit_end_i) begin
      sh_d   = {1'b1, sh_q[FRAME_W-1:1]};
      left_d = left_q - 1'b1;
      if (left_q == LW'(1)) begin
        busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      left_q <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
      busy_q <= busy_d;
    end
  end

  assign busy_o = busy_q;
  assign line_o = busy_q ? sh_q[0] : 1'b1;

endmodule

// File: rtl/async_tx_engine.sv
module async_tx_engine
  import async_tx_pkg::*;
#(
  parameter int QDEPTH = 4,
  parameter int OVS    = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       wr_bit8_i,
  input  logic       nine_bit_i,
  input  logic [1:0] parity_sel_i,
  input  logic       two_stop_i,
  input  logic       brk_i,
  output logic       txd_o,
  output logic       full_o,
  output logic       idle_o,
  output logic       irq_o
);

  localparam int WORD_W = $bits(tx_word_t);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  tx_word_t   wr_word, head_word;
  logic       q_empty, q_full, load, busy, bit_end, line;
  logic       irq_q, irq_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  assign wr_word.bit8 = wr_bit8_i;
  assign wr_word.data = wr_data_i;
  assign load         = !busy && !q_empty;

  tx_word_fifo #(.DEPTH(QDEPTH), .W(WORD_W)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .push_i  (wr_en_i),
    .din_i   (wr_word),
    .pop_i   (load),
    .dout_o  (head_word),
    .empty_o (q_empty),
    .full_o  (q_full)
  );

  tx_bit_timer #(.OVS(OVS)) u_timer (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .restart_i (load),
    .run_i     (busy),
    .tick_i    (tick16_i),
    .bit_end_o (bit_end)
  );

  tx_frame_shifter u_shift (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load_i     (load),
    .word_i     (head_word),
    .nine_bit_i (nine_bit_i),
    .par_i      (par_mode_e'(parity_sel_i)),
    .two_stop_i (two_stop_i),
    .bit_end_i  (bit_end),
    .busy_o     (busy),
    .line_o     (line)
  );

  assign irq_d = load;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign txd_o  = brk_i ? 1'b0 : line;
  assign full_o = q_full;
  assign idle_o = q_empty && !busy;
  assign irq_o  = irq_q;

endmodule

// File: rtl/async_tx_checker.sv
module async_tx_checker (
  input logic clk,
  input logic rst_n,
  input logic brk_i,
  input logic txd_o,
  input logic full_o,
  input logic idle_o,
  input logic irq_o
);

  // R10: break holds the line low
  p_break_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    brk_i |-> !txd_o);

  // R11: idle line stays high without break
  p_idle_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_o && !brk_i) |-> txd_o);

  // R7 / R9: a full queue is never idle
  p_full_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> !idle_o);

  // R8: interrupt coincides with the start bit
  p_irq_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !brk_i) |-> !txd_o);

  // R8: interrupt lasts one cycle
  p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  // R9: interrupt never while idle
  p_irq_not_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !idle_o);

endmodule

bind async_tx_engine async_tx_checker u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .brk_i  (brk_i),
  .txd_o  (txd_o),
  .full_o (full_o),
  .idle_o (idle_o),
  .irq_o  (irq_o)
);

// File: tb/tb_async_tx_engine.sv
module tb_async_tx_engine;

  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n, tick16, wr_en, wr_bit8, nine_bit, two_stop, brk;
  logic [7:0] wr_data;
  logic [1:0] par_sel;
  logic       txd, full, idle, irq;

  int checks = 0;
  int fails  = 0;
  int irq_cnt = 0;
  int div = 1;
  int tcnt = 0;

  async_tx_engine dut (
    .clk(clk), .rst_n(rst_n), .tick16_i(tick16), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .wr_bit8_i(wr_bit8), .nine_bit_i(nine_bit),
    .parity_sel_i(par_sel), .two_stop_i(two_stop), .brk_i(brk),
    .txd_o(txd), .full_o(full), .idle_o(idle), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    #1;
    tick16 = (tcnt == 0);
    tcnt = (tcnt + 1 >= div) ? 0 : tcnt + 1;
  end

  always @(posedge clk) if (irq === 1'b1) irq_cnt++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic exp_frame(input logic [7:0] d, input logic b8, input logic nb9,
                           input logic [1:0] ps, input logic ts,
                           output logic [11:0] f, output int n);
    bit ext;
    ext = nb9 || ps == 2'b01 || ps == 2'b10;
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < 8; i++) f[1+i] = d[i];
    n = 9;
    if (nb9) f[9] = b8;
    else if (ps == 2'b01) f[9] = ^d;
    else if (ps == 2'b10) f[9] = ~^d;
    if (ext) n++;
    n = n + (ts ? 2 : 1);
  endtask

  task automatic rx_check(input logic [11:0] f, input int n, input string tag);
    int t;
    bit ok;
    do @(negedge clk); while (txd !== 1'b0);
    check(irq === 1'b1, "R8 irq at start bit", int'(irq), 1);
    t = 0;
    ok = 1;
    for (int i = 0; i < n; i++) begin
      while (t < 16*i + 8) begin
        @(posedge clk);
        if (tick16) t++;
      end
      @(negedge clk);
      if (txd !== f[i]) begin
        ok = 0;
        $display("FAIL %s bit%0d actual=%0d expected=%0d", tag, i, txd, f[i]);
      end
    end
    checks++;
    if (!ok) fails++;
  endtask

  task automatic push(input logic [7:0] d, input logic b8);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_data = d; wr_bit8 = b8;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (idle !== 1'b1);
  endtask

  task automatic measure(input logic [7:0] d, output int n);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_data = d; wr_bit8 = 1'b0;
    @(posedge clk); #1;
    wr_en = 1'b0;
    n = 1;
    @(negedge clk);
    while (idle !== 1'b1) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [11:0] f;
    int n, ic, m0, m1;
    logic [7:0] vals [4];
    vals = '{8'h00, 8'hA5, 8'h3C, 8'hFF};
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; wr_bit8 = 1'b0;
    nine_bit = 1'b0; par_sel = 2'b00; two_stop = 1'b0; brk = 1'b0;
    repeat (4) @(negedge clk);
    check(txd === 1'b1 && idle === 1'b1, "R1 reset line/idle", int'({txd, idle}), 3);
    check(full === 1'b0 && irq === 1'b0, "R1 reset full/irq", int'({full, irq}), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(txd === 1'b1 && idle === 1'b1 && full === 1'b0 && irq === 1'b0,
          "R1 after reset", int'({txd, idle, full, irq}), 4'b1100);

    // R2 R3 R4 R5 R11: sweep of formats, stop counts and values
    for (int m = 0; m < 5; m++) begin
      for (int s = 0; s < 2; s++) begin
        for (int v = 0; v < 3; v++) begin
          nine_bit = (m == 4);
          par_sel  = (m == 4) ? 2'b01 : 2'(m);
          two_stop = s[0];
          ic = irq_cnt;
          exp_frame(vals[v+1-(m%2)], v[0], nine_bit, par_sel, two_stop, f, n);
          fork
            push(vals[v+1-(m%2)], v[0]);
            rx_check(f, n, "R2/R3/R4/R5 frame");
          join
          wait_idle();
          check(txd === 1'b1, "R11 line high after frame", int'(txd), 1);
          check(irq_cnt - ic == 1, "R8 one irq per frame", irq_cnt - ic, 1);
        end
      end
    end

    // R2: sparse enable pulses
    div = 3;
    nine_bit = 1'b0; par_sel = 2'b10; two_stop = 1'b1;
    exp_frame(8'h96, 1'b0, 1'b0, 2'b10, 1'b1, f, n);
    fork
      push(8'h96, 1'b0);
      rx_check(f, n, "R2 sparse ticks");
    join
    wait_idle();
    div = 1;

    // R6 R7: burst of six back-to-back writes, sixth meets a full queue
    nine_bit = 1'b0; par_sel = 2'b01; two_stop = 1'b1;
    ic = irq_cnt;
    fork
      begin
        for (int k = 0; k < 6; k++) begin
          @(posedge clk); #1;
          wr_en = 1'b1; wr_data = 8'(8'h11 * (k + 1)); wr_bit8 = 1'b0;
          @(negedge clk);
          if (k == 5) check(full === 1'b1, "R7 full with four queued", int'(full), 1);
          if (k == 3) check(full === 1'b0, "R7 not full at three", int'(full), 0);
        end
        @(posedge clk); #1 wr_en = 1'b0;
      end
      begin
        for (int k = 0; k < 5; k++) begin
          logic [11:0] fb;
          int nb;
          exp_frame(8'(8'h11 * (k + 1)), 1'b0, 1'b0, 2'b01, 1'b1, fb, nb);
          rx_check(fb, nb, "R6 queued frame order");
        end
      end
    join
    wait_idle();
    check(full === 1'b0, "R7 full cleared", int'(full), 0);
    begin
      bit low_seen;
      low_seen = 0;
      repeat (200) begin
        @(negedge clk);
        if (txd !== 1'b1) low_seen = 1;
      end
      check(!low_seen, "R7 dropped write never sent", int'(low_seen), 0);
    end
    check(irq_cnt - ic == 5, "R8/R7 irq count for burst", irq_cnt - ic, 5);
    check(idle === 1'b1, "R9 idle after burst", int'(idle), 1);

    // R9: idle low while a word waits or shifts
    fork
      push(8'h5A, 1'b0);
      begin
        @(posedge clk); @(negedge clk); @(negedge clk);
        check(idle === 1'b0, "R9 idle low when busy", int'(idle), 1'b0);
      end
    join
    wait_idle();

    // R10: break at idle and during a frame
    nine_bit = 1'b0; par_sel = 2'b00; two_stop = 1'b0;
    @(posedge clk); #1 brk = 1'b1;
    @(negedge clk);
    check(txd === 1'b0, "R10 break at idle", int'(txd), 0);
    check(idle === 1'b1, "R10 break leaves idle", int'(idle), 1);
    @(posedge clk); #1 brk = 1'b0;
    @(negedge clk);
    check(txd === 1'b1, "R11 line high after break", int'(txd), 1);

    measure(8'hC3, m0);
    check(m0 == 2 + 16*10, "R2 frame length in cycles", m0, 2 + 16*10);
    fork
      measure(8'hC3, m1);
      begin
        bit ok;
        ok = 1;
        repeat (40) @(posedge clk);
        #1 brk = 1'b1;
        repeat (50) begin
          @(negedge clk);
          if (txd !== 1'b0) ok = 0;
        end
        @(posedge clk); #1 brk = 1'b0;
        check(ok, "R10 line low during break", int'(ok), 1);
      end
    join
    check(m1 == m0, "R10 break keeps frame timing", m1, m0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule